// File: doc/BRIEF.md
# Token-Steered Column Data Loader

This block loads one line of gray-level column values for a row of display columns. Words arrive one at a time on a shared data bus. A single token moves through the column positions and picks which column register takes the current word, so no address travels with the data. The host, or the previous device in a chain, starts a line by pulsing the token input. It then streams words with a valid strobe. Each accepted word moves the token one position.

When the token leaves the last active column, the token output pulses in that same cycle, so a following device can take the very next word. A direction input picks the end where the token enters. A mode input shortens the chain to fewer columns. The loaded values sit in a temporary bank. A latch strobe copies the whole bank into an output bank in one cycle, so the next line can load while the current one is displayed.

Top module: `tok_col_loader`

## Requirements
- R1: After the asynchronous reset, every output column reads 0, no column holds the token and `token_o` is low.
- R2: A cycle with `token_i` high places the token at the entry column and captures nothing, even if `valid_i` is high in that cycle.
- R3: With `dir_i` = 0, the k-th word accepted after the token starts (k counting from 0) is stored in column ACTIVE-1-k, where ACTIVE is the active column count. The output bank carries column c at bits [c*6 +: 6] of `cols_o`.
- R4: With `dir_i` = 1, the k-th accepted word is stored in column k.
- R5: A cycle with `valid_i` low neither captures a word nor moves the token.
- R6: `token_o` is high only in the cycle where the last active column captures its word. After that cycle, further valid words are ignored until the next `token_i` pulse.
- R7: With `short_mode_i` = 1 the chain is 192 columns long. Columns 192 to 199 are never written, and `token_o` pulses on the 192nd accepted word. With `short_mode_i` = 0 the chain is 200 columns long.
- R8: The output bank changes only on a clock edge where `latch_i` is high. At that edge, every column takes its temporary value at once.
- R9: If a word is captured on the same edge as the latch, the output bank gets the temporary values from before that capture.
- R10: A `token_i` pulse while a line is partly loaded restarts the token at the entry column. Columns already written keep their values until they are overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dir_i | input | 1 | 0: token enters at the highest active column and moves down; 1: token enters at column 0 and moves up |
| short_mode_i | input | 1 | 1 selects the 192-column chain |
| token_i | input | 1 | Starts the token at the entry column |
| valid_i | input | 1 | Data word on `data_i` is valid |
| data_i | input | 6 | Gray-level word |
| latch_i | input | 1 | Copies the temporary bank to the output bank |
| token_o | output | 1 | Token carry-out to the next device |
| cols_o | output | 1200 | Output bank, column c at [c*6 +: 6] |

## Verification
Full lines are streamed in both directions and in both chain lengths. Each line uses a different arithmetic data pattern, so a word landing in the wrong column or an off-by-one entry point shows up as a mismatched column. Idle gaps are placed inside lines to separate stalling from advancing. A latch in the middle of a line separates the copy of the pre-edge bank from the copy of the post-edge bank. A restart with a simultaneous valid word shows whether the start cycle captures data. Surplus words after the carry-out, and a short line loaded over a full one, show whether out-of-range columns stay untouched.

// File: rtl/tok_loader_pkg.sv
package tok_loader_pkg;
  typedef enum logic {
    FILL_DOWN = 1'b0,
    FILL_UP   = 1'b1
  } fill_dir_e;
endpackage

// File: rtl/tok_chain.sv
module tok_chain
  import tok_loader_pkg::*;
#(
  parameter int NUM_COLS   = 200,
  parameter int SHORT_COLS = 192
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                dir_i,
  input  logic                short_i,
  input  logic                start_i,
  input  logic                adv_i,
  output logic [NUM_COLS-1:0] tok_o,
  output logic                last_o
);
  localparam int IW = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;

  fill_dir_e           dir;
  logic [IW-1:0]       last_col, entry_idx, exit_idx;
  logic [NUM_COLS-1:0] tok_q, tok_d;

  assign dir       = fill_dir_e'(dir_i);
  assign last_col  = short_i ? IW'(SHORT_COLS - 1) : IW'(NUM_COLS - 1);
  assign entry_idx = (dir == FILL_UP) ? '0 : last_col;
  assign exit_idx  = (dir == FILL_UP) ? last_col : '0;

  for (genvar p = 0; p < NUM_COLS; p++) begin : g_pos
    logic up_in, dn_in;
    if (p == 0) begin : g_lo_end
      assign up_in = 1'b0;
    end else begin : g_lo_mid
      assign up_in = tok_q[p-1] && (IW'(p-1) != exit_idx);
    end
    if (p == NUM_COLS - 1) begin : g_hi_end
      assign dn_in = 1'b0;
    end else begin : g_hi_mid
      assign dn_in = tok_q[p+1] && (IW'(p+1) != exit_idx);
    end
    assign tok_d[p] = start_i ? (IW'(p) == entry_idx) :
                      adv_i   ? ((dir == FILL_UP) ? up_in : dn_in) :
                                tok_q[p];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tok_q <= '0;
    else         tok_q <= tok_d;
  end

  assign tok_o  = tok_q;
  assign last_o = adv_i && tok_q[exit_idx];

  p_single_token_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tok_q));
  p_start_entry_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> tok_q[$past(entry_idx)]);
  p_stall_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !adv_i) |=> $stable(tok_q));
  p_exit_clears_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_o |=> (tok_q == '0));
endmodule

// File: rtl/col_bank.sv
module col_bank #(
  parameter int NUM_COLS = 200,
  parameter int DATA_W   = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_COLS-1:0]        cap_en_i,
  input  logic [DATA_W-1:0]          data_i,
  input  logic                       latch_i,
  output logic [NUM_COLS*DATA_W-1:0] cols_o
);
  localparam int BANK_W = NUM_COLS * DATA_W;

  logic [BANK_W-1:0] tmp_q, out_q;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          tmp_q[c*DATA_W +: DATA_W] <= '0;
      else if (cap_en_i[c]) tmp_q[c*DATA_W +: DATA_W] <= data_i;
    end

    p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_en_i[c] |=> (tmp_q[c*DATA_W +: DATA_W] == $past(data_i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      out_q <= '0;
    else if (latch_i) out_q <= tmp_q;
  end

  assign cols_o = out_q;

  p_out_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_i |=> $stable(cols_o));
  p_latch_copy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_i |=> (cols_o == $past(tmp_q)));
endmodule

// File: rtl/tok_col_loader.sv
module tok_col_loader #(
  parameter int NUM_COLS   = 200,
  parameter int SHORT_COLS = 192,
  parameter int DATA_W     = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       dir_i,
  input  logic                       short_mode_i,
  input  logic                       token_i,
  input  logic                       valid_i,
  input  logic [DATA_W-1:0]          data_i,
  input  logic                       latch_i,
  output logic                       token_o,
  output logic [NUM_COLS*DATA_W-1:0] cols_o
);
  logic                adv;
  logic [NUM_COLS-1:0] tok, cap_en;

  // start cycle never captures
  assign adv    = valid_i && !token_i;
  assign cap_en = tok & {NUM_COLS{adv}};

  tok_chain #(.NUM_COLS(NUM_COLS), .SHORT_COLS(SHORT_COLS)) u_chain (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .dir_i   (dir_i),
    .short_i (short_mode_i),
    .start_i (token_i),
    .adv_i   (adv),
    .tok_o   (tok),
    .last_o  (token_o)
  );

  col_bank #(.NUM_COLS(NUM_COLS), .DATA_W(DATA_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cap_en_i (cap_en),
    .data_i   (data_i),
    .latch_i  (latch_i),
    .cols_o   (cols_o)
  );

  p_tok_out_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_o |=> !token_o);
  p_tok_out_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    token_o |-> (valid_i && !token_i));
endmodule

// File: tb/tok_col_loader_tb_top.sv
module tok_col_loader_tb_top;
  localparam int N  = 200;
  localparam int NS = 192;
  localparam int W  = 6;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0;
  logic dir = 1'b0, short_m = 1'b0, tok_in = 1'b0, vld = 1'b0, lat = 1'b0;
  logic [W-1:0] dat = '0;
  logic tok_out;
  logic [N*W-1:0] cols;

  tok_col_loader #(.NUM_COLS(N), .SHORT_COLS(NS), .DATA_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .dir_i(dir), .short_mode_i(short_m),
    .token_i(tok_in), .valid_i(vld), .data_i(dat), .latch_i(lat),
    .token_o(tok_out), .cols_o(cols)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  int exp_tmp[N];
  int exp_out[N];
  int mpos = 0;
  bit mact = 0;

  function automatic int act_cols();
    return short_m ? NS : N;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(bit v, int d, bit ti, bit la, string req);
    int ex_exit;
    @(negedge clk);
    vld = v; dat = W'(d); tok_in = ti; lat = la;
    #1;
    ex_exit = dir ? act_cols() - 1 : 0;
    chk(req, int'(tok_out), int'(v && !ti && mact && mpos == ex_exit));
    @(posedge clk);
    if (la) for (int c = 0; c < N; c++) exp_out[c] = exp_tmp[c];
    if (ti) begin
      mact = 1;
      mpos = dir ? 0 : act_cols() - 1;
    end else if (v && mact) begin
      exp_tmp[mpos] = d % 64;
      if (mpos == ex_exit) mact = 0;
      else mpos = dir ? mpos + 1 : mpos - 1;
    end
  endtask

  task automatic idle();
    @(negedge clk);
    vld = 0; tok_in = 0; lat = 0;
  endtask

  task automatic check_out(string req);
    @(negedge clk);
    #1;
    for (int c = 0; c < N; c++) chk(req, int'(cols[c*W +: W]), exp_out[c]);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < N; c++) begin exp_tmp[c] = 0; exp_out[c] = 0; end
    repeat (3) @(posedge clk);
    check_out("R1");
    chk("R1", int'(tok_out), 0);
    @(negedge clk); rst_n = 1'b1;

    // full chain, downward fill, idle gaps inside the line
    dir = 0; short_m = 0;
    step(0, 0, 1, 0, "R2");
    for (int k = 0; k < N; k++) begin
      if (k % 17 == 5) step(0, 63, 0, 0, "R5");
      step(1, (k * 5 + 3) % 64, 0, 0, "R3,R6");
    end
    check_out("R8");
    step(1, 63, 0, 0, "R6");
    step(1, 62, 0, 0, "R6");
    step(0, 0, 0, 1, "R8");
    idle();
    check_out("R3,R6");

    // short chain, upward fill, latch mid-line
    dir = 1; short_m = 1;
    step(0, 0, 1, 0, "R2");
    for (int k = 0; k < NS; k++)
      step(1, (k * 7 + 1) % 64, 0, (k == 100), "R4,R7");
    idle();
    check_out("R9");
    step(0, 0, 0, 1, "R8");
    idle();
    check_out("R4,R7");

    // restart mid-line with a simultaneous valid word
    dir = 0; short_m = 0;
    step(0, 0, 1, 0, "R2");
    for (int k = 0; k < 10; k++) step(1, 42 + k, 0, 0, "R10");
    step(1, 63, 1, 0, "R2,R10");
    for (int k = 0; k < N; k++) step(1, (k * 3 + 11) % 64, 0, 0, "R10");
    step(0, 0, 0, 1, "R8");
    idle();
    check_out("R2,R10");

    // short chain, downward fill over a full line
    dir = 0; short_m = 1;
    step(0, 0, 1, 0, "R2");
    for (int k = 0; k < NS; k++) step(1, (k * 11 + 7) % 64, 0, 0, "R7");
    step(1, 1, 0, 0, "R6,R7");
    step(0, 0, 0, 1, "R8");
    idle();
    check_out("R7");

    done = 1;
    summary();
    $finish;
  end
endmodule